// File: doc/BRIEF.md
# Banked Dual Data Pointer Unit

This block holds two 16-bit data pointers for an 8-bit microcontroller core. Only one pointer is active at a time. A select bit in an auxiliary control register chooses it. Every pointer access from software or from the core goes to the active pointer. The other pointer keeps its contents, so code can hold one source and one destination address and switch between them with a single register write.

Software reaches the pointer bytes and the control register over a special-function-register (SFR) bus. The bus has an address, write data, a write strobe and combinational read data. The core has two further strobes: one adds 1 to the active pointer and one loads a full 16-bit value into it. The active pointer is always driven out for external-memory and code-relative addressing. Decoding of instructions, the indexed add and the external bus cycle belong to the core.

The control register has a general-purpose software flag at bit 3 and a bit 2 that always reads 0. A read-add-one-write of the whole register therefore flips the select bit. Any carry out of the low bits stops at bit 2 and never reaches the flag.

Top module: `dptr_unit`

## Requirements
- R1: After reset both pointers are 0000h, `bank_sel` is 0, `ptr_out` is 0000h, and bit 0 of the control register at address A2h reads 0.
- R2: Bit 0 of the control register (address A2h) is the select bit: 0 makes pointer 0 active and 1 makes pointer 1 active. `ptr_out` shows the active pointer from the cycle after the write.
- R3: Bit 2 of the control register cannot be written and always reads 0. Bits 1 and 7..4 also read 0.
- R4: Bit 3 of the control register is a software flag. It reads back what was last written to it and keeps its value through all other operations.
- R5: Reading the control register, adding 1 and writing the result back toggles the select bit and leaves the flag at bit 3 unchanged.
- R6: Address 82h reads and writes the low byte of the active pointer. Address 83h reads and writes its high byte.
- R7: A `ptr_inc` strobe adds 1 to the whole 16-bit active pointer. The low byte carries into the high byte, and FFFFh wraps to 0000h.
- R8: A `ptr_load` strobe writes `ptr_load_val` into the whole active pointer in one cycle.
- R9: The inactive pointer keeps its value through every access to the active pointer.
- R10: When a control register write and a pointer operation happen in the same cycle, the pointer operation acts on the pointer that was active before the write.
- R11: Priority on the active pointer within one cycle: `ptr_load` over `ptr_inc`, and `ptr_inc` over an SFR byte write. The lower-priority operation in that cycle is dropped.
- R12: SFR addresses other than 82h, 83h and A2h read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data, combinational from `sfr_addr` |
| ptr_inc | input | 1 | Add 1 to the active pointer |
| ptr_load | input | 1 | Load `ptr_load_val` into the active pointer |
| ptr_load_val | input | 16 | Value for the 16-bit load |
| ptr_out | output | 16 | Active pointer value |
| bank_sel | output | 1 | Current select bit |

## Verification
The bench builds the unit with its default parameters. These are 16-bit pointers over an 8-bit SFR bus at addresses 82h, 83h and A2h, with the select bit at bit 0, the hard zero at bit 2 and the flag at bit 3.

With these widths a single load reaches the FFFFh wrap and the 00FFh byte carry. The full control register can be written with FFh and read back to check which bits are held at zero. Same-cycle cases are driven on purpose: a select change together with an increment, load together with increment, and increment together with a byte write.

// File: rtl/dptr_pkg.sv
// Package: shared types for the banked data pointer unit.
// Assumes: a fixed count of two pointer banks chosen by a single select bit.
package dptr_pkg;
    localparam int BANKS = 2;

    // Which register an SFR address targets
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_CTL  = 2'd3
    } sfr_acc_e;
endpackage

// File: rtl/dptr_sfr_decode.sv
// Module: dptr_sfr_decode
// Maps an SFR address onto the register it targets (pointer low byte,
// pointer high byte, control register, or nothing).
// Assumes: the three addresses are distinct.
module dptr_sfr_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h83,
    parameter logic [ADDR_W-1:0] ADDR_CTL = 8'hA2
) (
    input  logic [ADDR_W-1:0]  addr,
    output dptr_pkg::sfr_acc_e acc
);
    // Address compare
    always_comb begin
        if (addr == ADDR_LO)       acc = dptr_pkg::ACC_LO;
        else if (addr == ADDR_HI)  acc = dptr_pkg::ACC_HI;
        else if (addr == ADDR_CTL) acc = dptr_pkg::ACC_CTL;
        else                       acc = dptr_pkg::ACC_NONE;
    end
endmodule

// File: rtl/dptr_ctl.sv
// Module: dptr_ctl
// Holds the stored bits of the auxiliary control register: the bank
// select bit and the software flag. Every other bit is not stored.
// Assumes: the caller asserts wr only for a write to the control address.
module dptr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_sel,
    input  logic wr_flag,
    output logic sel_q,
    output logic flag_q
);
    // Register update on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (wr) begin
            sel_q  <= wr_sel;
            flag_q <= wr_flag;
        end
    end

    AST_SEL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> sel_q == $past(wr_sel)); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(sel_q)); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(flag_q)); // R4
endmodule

// File: rtl/dptr_reg.sv
// Module: dptr_reg
// One data pointer bank. When enabled it takes, in order of priority,
// a full load, an increment, or a low or high byte write.
// When not enabled it holds its value.
// Assumes: PTR_W is larger than DATA_W and at most twice DATA_W.
module dptr_reg #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inc,
    input  logic              load,
    input  logic [PTR_W-1:0]  load_val,
    output logic [PTR_W-1:0]  q
);
    localparam int HI_W = PTR_W - DATA_W;

    // Pointer update with priority load > increment > byte write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            if (load)       q <= load_val;
            else if (inc)   q <= q + PTR_W'(1);
            else if (we_lo) q[DATA_W-1:0] <= wdata;
            else if (we_hi) q[PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        en && load |=> q == $past(load_val)); // R8
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && inc && !load |=> q == $past(q) + PTR_W'(1)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R9
endmodule

// File: rtl/dptr_unit.sv
// Module: dptr_unit (top)
// Two banked data pointers behind one pair of SFR byte addresses, with the
// bank chosen by the select bit of an auxiliary control register. Drives
// the active pointer to the core and serves combinational SFR reads.
// Assumes: SFR writes and core strobes are single-cycle pulses, and the
// core never needs the inactive pointer.
module dptr_unit #(
    parameter int                DATA_W   = 8,
    parameter int                PTR_W    = 16,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h83,
    parameter logic [ADDR_W-1:0] ADDR_CTL = 8'hA2,
    parameter int                SEL_BIT  = 0,
    parameter int                ZERO_BIT = 2,
    parameter int                FLAG_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              ptr_inc,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_load_val,
    output logic [PTR_W-1:0]  ptr_out,
    output logic              bank_sel
);
    localparam int BANKS = dptr_pkg::BANKS;
    localparam int HI_W  = PTR_W - DATA_W;

    dptr_pkg::sfr_acc_e acc;
    logic               ctl_wr;
    logic               flag;
    logic [DATA_W-1:0]  ctl_rd;
    logic [PTR_W-1:0]   bank_q [BANKS];

    dptr_sfr_decode #(
        .ADDR_W  (ADDR_W),
        .ADDR_LO (ADDR_LO),
        .ADDR_HI (ADDR_HI),
        .ADDR_CTL(ADDR_CTL)
    ) u_decode (
        .addr(sfr_addr),
        .acc (acc)
    );

    assign ctl_wr = sfr_we && (acc == dptr_pkg::ACC_CTL);

    dptr_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wr_sel (sfr_wdata[SEL_BIT]),
        .wr_flag(sfr_wdata[FLAG_BIT]),
        .sel_q  (bank_sel),
        .flag_q (flag)
    );

    // One pointer register per bank, enabled when the select matches
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        dptr_reg #(
            .DATA_W(DATA_W),
            .PTR_W (PTR_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (bank_sel == 1'(b)),
            .we_lo   (sfr_we && (acc == dptr_pkg::ACC_LO)),
            .we_hi   (sfr_we && (acc == dptr_pkg::ACC_HI)),
            .wdata   (sfr_wdata),
            .inc     (ptr_inc),
            .load    (ptr_load),
            .load_val(ptr_load_val),
            .q       (bank_q[b])
        );
    end

    assign ptr_out = bank_q[bank_sel];

    // Control register read image; unstored bits read 0
    always_comb begin
        ctl_rd           = '0;
        ctl_rd[SEL_BIT]  = bank_sel;
        ctl_rd[FLAG_BIT] = flag;
    end

    // SFR read mux
    always_comb begin
        case (acc)
            dptr_pkg::ACC_LO:  sfr_rdata = ptr_out[DATA_W-1:0];
            dptr_pkg::ACC_HI:  sfr_rdata = DATA_W'(ptr_out[PTR_W-1:DATA_W]);
            dptr_pkg::ACC_CTL: sfr_rdata = ctl_rd;
            default:           sfr_rdata = '0;
        endcase
    end

    AST_CTL_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CTL) |-> sfr_rdata[ZERO_BIT] == 1'b0); // R3
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != ADDR_LO && sfr_addr != ADDR_HI && sfr_addr != ADDR_CTL)
        |-> sfr_rdata == '0); // R12
    AST_SWITCH_OLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ptr_load |=> bank_q[$past(bank_sel)] == $past(ptr_load_val)); // R10
endmodule

// File: tb/dptr_unit_test.sv
// Directed bench for dptr_unit: one task per scenario, each checking its own results.
module dptr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_rdata;
    logic        ptr_inc = 1'b0;
    logic        ptr_load = 1'b0;
    logic [15:0] ptr_load_val = 16'h0000;
    logic [15:0] ptr_out;
    logic        bank_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dptr_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_wdata   (sfr_wdata),
        .sfr_we      (sfr_we),
        .sfr_rdata   (sfr_rdata),
        .ptr_inc     (ptr_inc),
        .ptr_load    (ptr_load),
        .ptr_load_val(ptr_load_val),
        .ptr_out     (ptr_out),
        .bank_sel    (bank_sel)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge, return at the next negedge
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic inc, input logic ld, input logic [15:0] lv);
        sfr_we = we; sfr_addr = a; sfr_wdata = d;
        ptr_inc = inc; ptr_load = ld; ptr_load_val = lv;
        @(posedge clk);
        @(negedge clk);
        sfr_we = 1'b0; ptr_inc = 1'b0; ptr_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 ptr_out", ptr_out, 16'h0000);
        check("R1 bank_sel", 16'(bank_sel), 16'h0);
        rd(8'hA2, v); check("R1 ctl bit0", 16'(v[0]), 16'h0);
        rd(8'h82, v); check("R1 low byte", 16'(v), 16'h00);
        rd(8'h83, v); check("R1 high byte", 16'(v), 16'h00);
    endtask

    task automatic t_byte_access();
        logic [7:0] v;
        wr(8'h82, 8'h34);
        wr(8'h83, 8'h12);
        check("R6 ptr_out after byte writes", ptr_out, 16'h1234);
        rd(8'h82, v); check("R6 low read", 16'(v), 16'h34);
        rd(8'h83, v); check("R6 high read", 16'(v), 16'h12);
    endtask

    task automatic t_bank_switch();
        logic [7:0] v;
        wr(8'hA2, 8'h01);
        check("R2 bank_sel=1", 16'(bank_sel), 16'h1);
        check("R9 bank1 untouched", ptr_out, 16'h0000);
        wr(8'h82, 8'hCD);
        wr(8'h83, 8'hAB);
        check("R6 bank1 value", ptr_out, 16'hABCD);
        wr(8'hA2, 8'h00);
        check("R2 bank_sel=0", 16'(bank_sel), 16'h0);
        check("R9 bank0 kept", ptr_out, 16'h1234);
        rd(8'h83, v); check("R6 high of bank0", 16'(v), 16'h12);
    endtask

    task automatic t_ctl_bits();
        logic [7:0] v;
        wr(8'hA2, 8'hFF);
        rd(8'hA2, v); check("R3 only bits 0 and 3 read back", 16'(v), 16'h09);
        wr(8'hA2, 8'h0C);
        rd(8'hA2, v); check("R3 bit2 write ignored", 16'(v), 16'h08);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);
        cyc(1'b1, 8'h82, 8'h00, 1'b0, 1'b0, 16'h0);
        rd(8'hA2, v); check("R4 flag held", 16'(v), 16'h08);
        wr(8'hA2, 8'h00);
        rd(8'hA2, v); check("R4 flag cleared", 16'(v), 16'h00);
        // restore bank0 to 1234
        cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 16'h1234);
    endtask

    task automatic t_ctl_increment();
        logic [7:0] v;
        wr(8'hA2, 8'h08);
        rd(8'hA2, v); wr(8'hA2, v + 8'h01);
        rd(8'hA2, v); check("R5 first inc", 16'(v), 16'h09);
        check("R5 bank_sel toggled on", 16'(bank_sel), 16'h1);
        rd(8'hA2, v); wr(8'hA2, v + 8'h01);
        rd(8'hA2, v); check("R5 second inc keeps flag", 16'(v), 16'h08);
        check("R5 bank_sel toggled off", 16'(bank_sel), 16'h0);
        wr(8'hA2, 8'h00);
    endtask

    task automatic t_increment();
        cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 16'h00FF);
        check("R8 load", ptr_out, 16'h00FF);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);
        check("R7 carry into high", ptr_out, 16'h0100);
        cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 16'hFFFF);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);
        check("R7 wrap", ptr_out, 16'h0000);
        cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 16'h1234);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0);
        check("R7 plain inc", ptr_out, 16'h1235);
        wr(8'hA2, 8'h01);
        check("R9 bank1 after bank0 ops", ptr_out, 16'hABCD);
        wr(8'hA2, 8'h00);
    endtask

    task automatic t_same_cycle();
        cyc(1'b1, 8'hA2, 8'h01, 1'b1, 1'b0, 16'h0);
        check("R10 select switched", 16'(bank_sel), 16'h1);
        check("R10 bank1 not incremented", ptr_out, 16'hABCD);
        cyc(1'b1, 8'hA2, 8'h00, 1'b0, 1'b1, 16'h5555);
        check("R10 bank0 incremented by old select", ptr_out, 16'h1236);
        wr(8'hA2, 8'h01);
        check("R10 load went to bank1", ptr_out, 16'h5555);
        wr(8'hA2, 8'h00);
    endtask

    task automatic t_priority();
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 16'h4000);
        check("R11 load over inc", ptr_out, 16'h4000);
        cyc(1'b1, 8'h82, 8'h77, 1'b1, 1'b0, 16'h0);
        check("R11 inc over byte write", ptr_out, 16'h4001);
        cyc(1'b1, 8'h83, 8'h99, 1'b0, 1'b1, 16'h2222);
        check("R11 load over high write", ptr_out, 16'h2222);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h90, 8'hFF);
        check("R12 pointer unchanged", ptr_out, 16'h2222);
        check("R12 select unchanged", 16'(bank_sel), 16'h0);
        rd(8'hA2, v); check("R12 ctl unchanged", 16'(v), 16'h00);
        rd(8'h90, v); check("R12 unmapped read", 16'(v), 16'h00);
        rd(8'h84, v); check("R12 neighbour read", 16'(v), 16'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_access();
        t_bank_switch();
        t_ctl_bits();
        t_ctl_increment();
        t_increment();
        t_same_cycle();
        t_priority();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule